// File: doc/BRIEF.md
# Current-Cell Trim Calibration Sequencer

This block runs a one-shot foreground calibration of the unit current cells in the upper, thermometer-coded segment of a current-steering converter. Each cell has a six-bit trim word that adds up to 63 units of correction current. A shared master reference has a trim word of the same kind. A single comparator reports whether the current being trimmed is still below its target. The block settles the master first and then the cells. Each trim is a successive-approximation search over the six trim bits.

A start pulse begins a run. The master reference is first searched against cell 0, and cell 0's trim is held at mid-scale while this happens. The master's final word is then kept inside the block and drives the master trim from then on. Next, cell 0 and every later cell, in ascending index order, are searched against the adjusted master. Each finished cell word goes out on a shared data bus together with a one-hot write strobe that loads the cell's own static trim register. When the run ends, the block raises a one-cycle done flag and drops the clock enable to its calibration logic. It then stays idle until the next start.

Top module: `trim_cal_seq`

## Requirements
- R1: After reset, busy, done, cal_clk_en, master_we and every cell_we bit are 0, and master_trim and cell_trim both read mid-scale (32).
- R2: A start pulse sampled while idle makes the block busy from the next cycle. In that first busy cycle tgt_master is 1, cell_sel is 0, and both master_trim and cell_trim are 32.
- R3: While tgt_master is 1, cell_trim stays at 32 and cell_sel stays at 0. The master's final word is the search result of master_trim against cell 0 at mid-scale.
- R4: Each search tries bit 5 first and bit 0 last. A trial word is the bits already decided plus the bit under test set to 1. The tested bit is kept when cmp_below is 1 and cleared when it is 0.
- R5: The settle_cycles value S is captured at the start of each search. Each trial is held for S+1 cycles, and cmp_below is sampled in the last of them. One search plus its write therefore takes 6*(S+1)+1 cycles, and a full run keeps busy high for (N_CELLS+1)*(6*(S+1)+1) cycles.
- R6: After the master, cells are searched one at a time in ascending index order, 0 to N_CELLS-1. In each cell search, cell_trim carries the trial word and master_trim carries the stored master word.
- R7: The cycle after the sixth decision of a search is a write cycle. In that cycle exactly one strobe is high: master_we for the master, or cell_we bit k for cell k. wr_data holds the final word during that cycle.
- R8: A start pulse that arrives while busy has no effect. Run length and written words are unchanged.
- R9: done is high for exactly one cycle, the cycle right after the last cell's write. busy and cal_clk_en are 0 in that cycle. cal_clk_en is high exactly while busy is high.
- R10: After a run, master_trim keeps the master's final word until the next run or reset. A new start recalibrates from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a calibration run |
| settle_cycles | input | SETTLE_W | Extra cycles each trial is held before the comparator is sampled |
| cmp_below | input | 1 | 1 when the trimmed current is below its target |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle pulse after the final write |
| cal_clk_en | output | 1 | Clock enable for calibration logic |
| tgt_master | output | 1 | 1 while the master reference is being trimmed |
| cell_sel | output | CELL_W | Index of the cell being trimmed, or the reference cell in the master phase |
| master_trim | output | 6 | Trim word applied to the master reference |
| cell_trim | output | 6 | Trim word applied to the selected cell |
| master_we | output | 1 | Write strobe for the master result |
| cell_we | output | N_CELLS | One-hot write strobes for the cell trim registers |
| wr_data | output | 6 | Final trim word during a write cycle |

## Verification
The bench models each current as a base offset plus the trim word. It delays the comparator by up to two cycles, so a design that samples before the settle window ends returns wrong words, and one that miscounts the settle window changes the run length. The cell offsets are spread widely enough that some cells saturate at 0 and others at 63. An inverted keep rule, a wrong bit order or a missing final decision would then show up as wrong written words. A start pulse injected mid-run would lengthen the run or duplicate writes if it restarted anything. A reset in the middle of a run must return the block to idle, and a released mid-scale hold on the reference cell would move the master result.

// File: rtl/trimcal_pkg.sv
package trimcal_pkg;

    localparam int TRIM_W = 6;
    localparam int BIDX_W = $clog2(TRIM_W);

    typedef logic [TRIM_W-1:0] trim_t;
    typedef logic [BIDX_W-1:0] bidx_t;

    localparam trim_t TRIM_MID = trim_t'(1) << (TRIM_W - 1);
    localparam bidx_t TOP_BIT  = bidx_t'(TRIM_W - 1);

    typedef enum logic [1:0] {
        SAR_IDLE,
        SAR_SETTLE,
        SAR_WRITE
    } sar_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_MASTER,
        SEQ_CELLS,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic  wr;
        trim_t word;
    } sar_out_t;

    function automatic trim_t bit_mask(input bidx_t idx);
        return trim_t'(1) << idx;
    endfunction

endpackage

// File: rtl/sar_engine.sv
module sar_engine
    import trimcal_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [SETTLE_W-1:0] settle,
    input  logic                cmp_below,
    output trim_t               trial,
    output sar_out_t            res
);

    sar_state_e          state;
    bidx_t               bit_idx;
    logic [SETTLE_W-1:0] cnt;
    logic [SETTLE_W-1:0] settle_q;
    trim_t               final_q;
    trim_t               decided;
    logic                sample_now;

    assign sample_now = (state == SAR_SETTLE) && (cnt == settle_q);

    always_comb begin
        if (cmp_below) decided = trial;
        else           decided = trial & ~bit_mask(bit_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SAR_IDLE;
            trial    <= TRIM_MID;
            bit_idx  <= '0;
            cnt      <= '0;
            settle_q <= '0;
            final_q  <= '0;
        end else if (go && state != SAR_SETTLE) begin
            state    <= SAR_SETTLE;
            trial    <= TRIM_MID;
            bit_idx  <= TOP_BIT;
            cnt      <= '0;
            settle_q <= settle;
        end else begin
            case (state)
                SAR_SETTLE: begin
                    if (sample_now) begin
                        cnt <= '0;
                        if (bit_idx == '0) begin
                            trial   <= decided;
                            final_q <= decided;
                            state   <= SAR_WRITE;
                        end else begin
                            trial   <= decided | bit_mask(bit_idx - 1'b1);
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SAR_WRITE: state <= SAR_IDLE;
                default:   state <= SAR_IDLE;
            endcase
        end
    end

    assign res.wr   = (state == SAR_WRITE);
    assign res.word = final_q;

    p_trial_held_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SAR_SETTLE && !sample_now) |=> $stable(trial));

    p_keep_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (sample_now && cmp_below) |=> trial[$past(bit_idx)]);

    p_clear_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (sample_now && !cmp_below) |=> !trial[$past(bit_idx)]);

    p_write_single_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SAR_WRITE) |=> (state != SAR_WRITE));

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import trimcal_pkg::*;
#(
    parameter int N_CELLS = 31,
    parameter int CELL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  sar_out_t          sar_res,
    output logic              sar_go,
    output logic              busy,
    output logic              done,
    output logic              tgt_master,
    output logic              cell_phase,
    output logic [CELL_W-1:0] cell_idx,
    output trim_t             master_word
);

    localparam logic [CELL_W-1:0] LAST_IDX = CELL_W'(N_CELLS - 1);

    seq_state_e state;
    logic       last_cell;

    assign last_cell  = (state == SEQ_CELLS) && (cell_idx == LAST_IDX);
    assign busy       = (state == SEQ_MASTER) || (state == SEQ_CELLS);
    assign done       = (state == SEQ_DONE);
    assign tgt_master = (state == SEQ_MASTER);
    assign cell_phase = (state == SEQ_CELLS);
    assign sar_go     = ((state == SEQ_IDLE) && start) ||
                        (busy && sar_res.wr && !last_cell);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            cell_idx    <= '0;
            master_word <= TRIM_MID;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state    <= SEQ_MASTER;
                        cell_idx <= '0;
                    end
                end
                SEQ_MASTER: begin
                    if (sar_res.wr) begin
                        master_word <= sar_res.word;
                        state       <= SEQ_CELLS;
                        cell_idx    <= '0;
                    end
                end
                SEQ_CELLS: begin
                    if (sar_res.wr) begin
                        if (last_cell) state <= SEQ_DONE;
                        else           cell_idx <= cell_idx + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    p_master_first_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && start) |=> (state == SEQ_MASTER && cell_idx == '0));

    p_cell_order_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_CELLS && sar_res.wr && !last_cell)
            |=> (cell_idx == $past(cell_idx) + 1'b1));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !sar_res.wr) |=> (busy && $stable(cell_idx) && $stable(state)));

    p_done_once_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/we_decoder.sv
module we_decoder #(
    parameter int N_CELLS = 31,
    parameter int CELL_W  = 5
) (
    input  logic               en,
    input  logic [CELL_W-1:0]  idx,
    output logic [N_CELLS-1:0] strobe
);

    for (genvar g = 0; g < N_CELLS; g++) begin : g_strobe
        assign strobe[g] = en && (idx == CELL_W'(g));
    end

endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
    import trimcal_pkg::*;
#(
    parameter int N_CELLS  = 31,
    parameter int SETTLE_W = 8,
    localparam int CELL_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                cmp_below,
    output logic                busy,
    output logic                done,
    output logic                cal_clk_en,
    output logic                tgt_master,
    output logic [CELL_W-1:0]   cell_sel,
    output logic [TRIM_W-1:0]   master_trim,
    output logic [TRIM_W-1:0]   cell_trim,
    output logic                master_we,
    output logic [N_CELLS-1:0]  cell_we,
    output logic [TRIM_W-1:0]   wr_data
);

    sar_out_t sar_res;
    trim_t    trial;
    trim_t    master_word;
    logic     sar_go;
    logic     cell_phase;

    sar_engine #(.SETTLE_W(SETTLE_W)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .go        (sar_go),
        .settle    (settle_cycles),
        .cmp_below (cmp_below),
        .trial     (trial),
        .res       (sar_res)
    );

    cal_sequencer #(.N_CELLS(N_CELLS), .CELL_W(CELL_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sar_res     (sar_res),
        .sar_go      (sar_go),
        .busy        (busy),
        .done        (done),
        .tgt_master  (tgt_master),
        .cell_phase  (cell_phase),
        .cell_idx    (cell_sel),
        .master_word (master_word)
    );

    we_decoder #(.N_CELLS(N_CELLS), .CELL_W(CELL_W)) u_dec (
        .en     (cell_phase && sar_res.wr),
        .idx    (cell_sel),
        .strobe (cell_we)
    );

    assign cal_clk_en  = busy;
    assign master_trim = tgt_master ? trial : master_word;
    assign cell_trim   = cell_phase ? trial : TRIM_MID;
    assign master_we   = tgt_master && sar_res.wr;
    assign wr_data     = sar_res.word;

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({master_we, cell_we}));

    p_done_follows_last_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cell_we[N_CELLS-1]));

    p_master_before_cells_r6: assert property (@(posedge clk) disable iff (rst)
        master_we |=> (busy && !tgt_master && cell_sel == '0));

    p_master_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(master_we)) |-> $stable(master_trim));

endmodule

// File: tb/test_trim_cal_seq.sv
module test_trim_cal_seq;

    localparam int NC = 31;
    localparam int NV = 5;
    // fields: settle, comparator latency (0 or 2), seed, inject start mid-run
    localparam int VEC [NV][4] = '{
        '{0, 0, 1, 0},
        '{2, 2, 2, 0},
        '{3, 2, 3, 1},
        '{5, 2, 4, 0},
        '{2, 2, 7, 1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] settle_cycles = '0;
    logic       cmp_below;
    logic       busy, done, cal_clk_en, tgt_master, master_we;
    logic [4:0] cell_sel;
    logic [5:0] master_trim, cell_trim, wr_data;
    logic [NC-1:0] cell_we;

    int n_checks = 0;
    int n_fails  = 0;

    int cbase [NC];
    int mbase = 0;
    int lat   = 0;
    logic cmp_raw, q1 = 1'b0, q2 = 1'b0, q3 = 1'b0;

    always #10 clk = ~clk;

    trim_cal_seq i_trim_cal_seq (
        .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
        .cmp_below(cmp_below), .busy(busy), .done(done), .cal_clk_en(cal_clk_en),
        .tgt_master(tgt_master), .cell_sel(cell_sel), .master_trim(master_trim),
        .cell_trim(cell_trim), .master_we(master_we), .cell_we(cell_we),
        .wr_data(wr_data)
    );

    always_comb begin
        int mc, cc;
        mc = mbase + int'(master_trim);
        cc = cbase[cell_sel] + int'(cell_trim);
        cmp_raw = tgt_master ? (mc < cc) : (cc < mc);
    end

    always @(negedge clk) begin
        q3 <= q2;
        q2 <= q1;
        q1 <= cmp_raw;
    end

    assign cmp_below = (lat == 0) ? cmp_raw : q3;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int sar_ref(input int base, input int target);
        int w = 0;
        for (int b = 5; b >= 0; b--) begin
            int t = w | (1 << b);
            if (base + t < target) w = t;
        end
        return w;
    endfunction

    task automatic run_cal(input int s, input int l, input int seed, input int inj);
        int exp_m, busy_cnt, guard, next_cell, k, nstrobe, r3_bad, r4_bad, m_writes;
        int exp_c [NC];
        bit done_seen;
        lat = l;
        for (int i = 0; i < NC; i++) cbase[i] = (i * 37 + seed * 11) % 97;
        mbase = cbase[0] + ((seed * 17) % 50) - 10;
        exp_m = sar_ref(mbase, cbase[0] + 32);
        for (int i = 0; i < NC; i++) exp_c[i] = sar_ref(cbase[i], mbase + exp_m);

        start = 1'b1;
        settle_cycles = 8'(s);
        @(negedge clk);
        start = 1'b0;
        // R2: first busy cycle
        check(busy && tgt_master && cell_sel == 0, "R2 first cycle flags", {busy, tgt_master}, 3);
        check(master_trim == 32 && cell_trim == 32, "R2 initial trims", master_trim, 32);

        busy_cnt = 0; guard = 0; next_cell = 0; r3_bad = 0; r4_bad = 0; m_writes = 0;
        done_seen = 0;
        while (!done_seen && guard < 100000) begin
            if (busy) busy_cnt++;
            start = (inj != 0 && busy_cnt == 50);
            if (busy && tgt_master) begin
                int i, st, exp_t;
                if (cell_trim != 32 || cell_sel != 0) r3_bad++;
                i = busy_cnt - 1;
                if (i < 6 * (s + 1) && (i % (s + 1)) == 0) begin
                    st = i / (s + 1);
                    exp_t = (exp_m & ~((1 << (6 - st)) - 1)) | (1 << (5 - st));
                    if (int'(master_trim) != exp_t) r4_bad++;
                end
            end
            if (master_we) begin
                m_writes++;
                check(int'(wr_data) == exp_m, "R3 master result", wr_data, exp_m);
            end
            if (cell_we != '0) begin
                nstrobe = 0; k = -1;
                for (int j = 0; j < NC; j++) if (cell_we[j]) begin nstrobe++; k = j; end
                check(nstrobe == 1 && !master_we, "R7 single strobe", nstrobe, 1);
                check(k == next_cell, "R6 cell order", k, next_cell);
                if (k >= 0) check(int'(wr_data) == exp_c[k], "R7 cell word", wr_data, exp_c[k]);
                if (k >= 0 && k < NC) begin
                    // R6: master word drives master_trim during cell phase
                    if (int'(master_trim) != exp_m) r3_bad++;
                end
                next_cell++;
            end
            if (done) begin
                done_seen = 1;
                check(!busy && !cal_clk_en, "R9 idle during done", {busy, cal_clk_en}, 0);
            end else begin
                if (cal_clk_en != busy) r4_bad += 0;
                check(cal_clk_en == busy, "R9 clock enable tracks busy", cal_clk_en, busy);
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        check(guard < 100000, "R9 watchdog", guard, 0);
        check(r3_bad == 0, "R3 reference hold", r3_bad, 0);
        check(r4_bad == 0, "R4 trial sequence", r4_bad, 0);
        check(m_writes == 1, "R7 master written once", m_writes, 1);
        check(next_cell == NC, "R6 all cells written", next_cell, NC);
        check(busy_cnt == (NC + 1) * (6 * (s + 1) + 1), "R5 run length", busy_cnt,
              (NC + 1) * (6 * (s + 1) + 1));
        if (inj != 0) check(busy_cnt == (NC + 1) * (6 * (s + 1) + 1), "R8 start ignored",
                            busy_cnt, (NC + 1) * (6 * (s + 1) + 1));
        check(!done && !busy, "R9 done single pulse", done, 0);
        check(int'(master_trim) == exp_m, "R10 master word held", master_trim, exp_m);
        repeat (3) @(negedge clk);
        check(int'(master_trim) == exp_m && !busy, "R10 hold while idle", master_trim, exp_m);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) cbase[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !cal_clk_en, "R1 reset flags", {busy, done, cal_clk_en}, 0);
        check(!master_we && cell_we == '0, "R1 reset strobes", cell_we, 0);
        check(master_trim == 32 && cell_trim == 32, "R1 reset trims", master_trim, 32);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && master_trim == 32, "R1 idle after release", busy, 0);

        for (int v = 0; v < NV; v++)
            run_cal(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

        // R1: reset in the middle of a run returns to idle at mid-scale
        start = 1'b1;
        settle_cycles = 8'd1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !cal_clk_en && cell_we == '0, "R1 mid-run reset", busy, 0);
        check(master_trim == 32 && cell_trim == 32, "R1 mid-run reset trims", master_trim, 32);

        // R10: a fresh run after reset recalibrates
        run_cal(1, 0, 9, 0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule